// File: doc/BRIEF.md
# Partial-Width Integer ALU Micro-Op

This block is the integer execution stage for a single register-to-register micro-operation on 64-bit registers. It performs eight operations: add, add with carry-in, subtract, subtract with borrow-in, bitwise AND, OR and XOR, and a conditional move. Each operation works at an operand width of 1, 2, 4 or 8 bytes. The second operand is either a full source register or an 8-bit immediate that is zero-extended. The caller supplies the old destination value and the old flag word. The block returns the new destination and the new flag word one clock after the operation is issued.

The result replaces only the low bytes of the destination that the operand width covers; the higher bytes keep their old contents. Condition flags are computed at the selected width. A per-operation enable mask chooses which flag bits are written, so one micro-operation can update carry alone, all six arithmetic flags, or none. The block does not evaluate conditions. For the conditional move, the decision comes in as a single condition-true input, which is evaluated elsewhere.

Top module: `pw_alu`

## Requirements
- R1: `op_size` selects the operand width: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. For every code other than the conditional move, the destination bytes at and above that width come from `dst_old` unchanged.
- R2: Opcodes are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 OR, 6 XOR and 7 CMOV. The result of ADD and SUB wraps modulo 2^(8·width).
- R3: When `use_imm` is 1, the second operand is `imm` zero-extended to 64 bits. When it is 0, the second operand is `src2`.
- R4: ADC adds the old carry flag (`flags_old` bit 0) as carry-in. SBB subtracts it as a borrow.
- R5: A new flag bit is written only where `flag_en` has a 1. Only bits 0 (carry), 2 (parity), 4 (nibble carry), 6 (zero), 7 (sign) and 11 (overflow) can be written. All other bits, and all bits when `flag_en` is zero, equal `flags_old`.
- R6: AND, OR and XOR write 0 to carry, overflow and nibble carry where these are enabled. They compute zero, sign and parity from the logic result.
- R7: CMOV with `cond_true` at 1 returns `src1` with its low width bytes replaced by the second operand. With `cond_true` at 0 it returns `dst_old`. CMOV never changes any flag.
- R8: Flags are computed at the operand width. Zero is set when the width result is 0. Sign is the result's top bit. Parity is 1 when the low result byte has an even number of ones. Carry is the carry out for add forms and the borrow for subtract forms. Overflow is signed overflow. Nibble carry is the carry or borrow out of bit 3.
- R9: The outputs are registered. `res_vld` is `op_vld` delayed by one clock, and `dst_new`/`flags_new` change only after a cycle with `op_vld` high. Reset drives all three outputs to 0.
- R10: Opcodes 8 to 15 return `dst_old` and `flags_old` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_vld | input | 1 | Operation issued this cycle |
| op_code | input | 4 | Operation select |
| op_size | input | 2 | Operand width code |
| use_imm | input | 1 | Second operand from immediate |
| src1 | input | 64 | First source operand |
| src2 | input | 64 | Second source operand, register form |
| imm | input | 8 | Second source operand, immediate form |
| dst_old | input | 64 | Current destination value |
| flags_old | input | 12 | Current flag word |
| flag_en | input | 12 | Per-bit flag write enable |
| cond_true | input | 1 | Condition outcome for CMOV |
| res_vld | output | 1 | Result valid |
| dst_new | output | 64 | Merged destination result |
| flags_new | output | 12 | Merged flag word |

## Verification
The hardest case to reach is a narrow-width result whose flags would differ if they were taken at bit 63. An example is a 1-byte add that overflows in signed terms while the upper source bytes hold values that would carry on into a wide sum. The stimulus reaches this case by placing non-zero patterns in the upper bytes of `src1`, `src2` and `dst_old` for every directed narrow operation. It then adds a long run of pseudo-random operations at all four widths, with random flag masks and random old flags. A scoreboard model compares each result against the width rules.

// File: rtl/pw_alu_pkg.sv
// Shared definitions for the partial-width ALU: opcode values and flag
// bit positions. Assumes a 12-bit flag word.
package pw_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CMOV = 4'd7
    } op_e;

    localparam int FLAG_W   = 12;
    localparam int FB_CARRY = 0;
    localparam int FB_PAR   = 2;
    localparam int FB_AUX   = 4;
    localparam int FB_ZERO  = 6;
    localparam int FB_SIGN  = 7;
    localparam int FB_OVF   = 11;

    localparam logic [FLAG_W-1:0] FLAG_WR_MASK =
        (FLAG_W'(1) << FB_CARRY) | (FLAG_W'(1) << FB_PAR)  |
        (FLAG_W'(1) << FB_AUX)   | (FLAG_W'(1) << FB_ZERO) |
        (FLAG_W'(1) << FB_SIGN)  | (FLAG_W'(1) << FB_OVF);

endpackage

// File: rtl/pw_alu_opsel.sv
// Operand selection and width decode.
// Picks the second operand (register or zero-extended immediate) and turns
// the size code into a byte enable, a bit lane mask and a one-hot top bit.
// Assumes DATA_W is a power-of-two multiple of 8.
module pw_alu_opsel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    localparam int NBYTES = DATA_W / 8,
    localparam int SZ_W   = $clog2($clog2(NBYTES) + 1)
) (
    input  logic [SZ_W-1:0]   op_size,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src2,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] op2,
    output logic [NBYTES-1:0] byte_en,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] top_bit
);

    // Second operand mux with zero extension of the immediate.
    assign op2 = use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm} : src2;

    // One enable per byte lane below the selected width.
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign byte_en[i] = (i < (1 << op_size));
        assign lane_mask[8*i +: 8] = {8{byte_en[i]}};
    end

    // Highest selected bit, used for sign and carry-out.
    assign top_bit = lane_mask & ~(lane_mask >> 1);

endmodule

// File: rtl/pw_alu_core.sv
// Arithmetic and logic core.
// Computes the width-limited result and the candidate flag vector. It also
// decides whether the destination and flags are to be written, and whether
// the merge base is src1 (conditional move) or the old destination.
// Assumes operands are masked here by lane_mask.
module pw_alu_core
    import pw_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] op2,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] top_bit,
    input  logic              cf_in,
    input  logic              cond_true,
    output logic [DATA_W-1:0] res,
    output logic [FLAG_W-1:0] flg_calc,
    output logic              dst_we,
    output logic              flg_we,
    output logic              base_src1
);

    logic              is_arith, is_logic, is_mov, is_sub, cin;
    logic [DATA_W-1:0] b_x, lres;
    logic [DATA_W:0]   sum;
    logic              carry_out, sgn_a, sgn_b, sgn_r;

    // Decode operation class and the carry-in of the adder.
    always_comb begin
        is_arith = 1'b0;
        is_logic = 1'b0;
        is_mov   = 1'b0;
        is_sub   = 1'b0;
        cin      = 1'b0;
        case (op_code)
            OP_ADD:  is_arith = 1'b1;
            OP_ADC:  begin is_arith = 1'b1; cin = cf_in; end
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; cin = 1'b1; end
            OP_SBB:  begin is_arith = 1'b1; is_sub = 1'b1; cin = ~cf_in; end
            OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
            OP_CMOV: is_mov = 1'b1;
            default: ;
        endcase
    end

    // Subtraction runs as addition of the complement.
    assign b_x = is_sub ? ~op2 : op2;
    assign sum = {1'b0, src1 & lane_mask} + {1'b0, b_x & lane_mask}
               + {{DATA_W{1'b0}}, cin};

    // Bitwise result for the logic class.
    always_comb begin
        case (op_code)
            OP_AND:  lres = src1 & op2;
            OP_OR:   lres = src1 | op2;
            default: lres = src1 ^ op2;
        endcase
    end

    // Width-limited result of the selected class.
    always_comb begin
        if (is_arith)      res = sum[DATA_W-1:0] & lane_mask;
        else if (is_logic) res = lres & lane_mask;
        else               res = op2 & lane_mask;
    end

    assign carry_out = |(sum[DATA_W:1] & top_bit);
    assign sgn_a     = |(src1 & top_bit);
    assign sgn_b     = |(b_x & top_bit);
    assign sgn_r     = |(res & top_bit);

    // Candidate flags at the operand width; logic ops clear CF, OF and AF.
    always_comb begin
        flg_calc           = '0;
        flg_calc[FB_PAR]   = ~^res[7:0];
        flg_calc[FB_ZERO]  = (res == '0);
        flg_calc[FB_SIGN]  = sgn_r;
        if (is_arith) begin
            flg_calc[FB_CARRY] = carry_out ^ is_sub;
            flg_calc[FB_OVF]   = (sgn_a == sgn_b) && (sgn_r != sgn_a);
            flg_calc[FB_AUX]   = src1[4] ^ op2[4] ^ sum[4];
        end
    end

    assign dst_we    = is_arith | is_logic | (is_mov & cond_true);
    assign flg_we    = is_arith | is_logic;
    assign base_src1 = is_mov;

endmodule

// File: rtl/pw_alu_merge.sv
// Result merge.
// Writes the result only into the enabled byte lanes of the destination,
// taking other lanes from src1 (conditional move) or the old destination.
// It then writes only the enabled, writable flag bits.
module pw_alu_merge
    import pw_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] dst_old,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] res,
    input  logic [NBYTES-1:0] byte_en,
    input  logic              base_src1,
    input  logic              dst_we,
    input  logic [FLAG_W-1:0] flags_old,
    input  logic [FLAG_W-1:0] flg_calc,
    input  logic [FLAG_W-1:0] flg_en,
    input  logic              flg_we,
    output logic [DATA_W-1:0] dst_out,
    output logic [FLAG_W-1:0] flags_out
);

    logic [FLAG_W-1:0] wmask;

    // Per-lane choice between result, merge base and old destination.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_comb begin
            if (!dst_we)        dst_out[8*i +: 8] = dst_old[8*i +: 8];
            else if (byte_en[i]) dst_out[8*i +: 8] = res[8*i +: 8];
            else if (base_src1)  dst_out[8*i +: 8] = src1[8*i +: 8];
            else                 dst_out[8*i +: 8] = dst_old[8*i +: 8];
        end
    end

    // Bitwise flag merge under the enable and writable masks.
    assign wmask     = flg_we ? (flg_en & FLAG_WR_MASK) : '0;
    assign flags_out = (flags_old & ~wmask) | (flg_calc & wmask);

endmodule

// File: rtl/pw_alu.sv
// Partial-width integer ALU micro-op, top level.
// Gives a registered result one cycle after op_vld. Outputs hold when no
// operation is issued. Synchronous active-low reset clears all outputs.
module pw_alu
    import pw_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    localparam int NBYTES = DATA_W / 8,
    localparam int SZ_W   = $clog2($clog2(NBYTES) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_vld,
    input  logic [3:0]        op_code,
    input  logic [SZ_W-1:0]   op_size,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [FLAG_W-1:0] flags_old,
    input  logic [FLAG_W-1:0] flag_en,
    input  logic              cond_true,
    output logic              res_vld,
    output logic [DATA_W-1:0] dst_new,
    output logic [FLAG_W-1:0] flags_new
);

    logic [DATA_W-1:0] op2, lane_mask, top_bit, res, dst_nx;
    logic [NBYTES-1:0] byte_en;
    logic [FLAG_W-1:0] flg_calc, flg_nx;
    logic              dst_we, flg_we, base_src1;

    pw_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .op_size(op_size), .use_imm(use_imm), .src2(src2), .imm(imm),
        .op2(op2), .byte_en(byte_en), .lane_mask(lane_mask), .top_bit(top_bit)
    );

    pw_alu_core #(.DATA_W(DATA_W)) u_core (
        .op_code(op_code), .src1(src1), .op2(op2), .lane_mask(lane_mask),
        .top_bit(top_bit), .cf_in(flags_old[FB_CARRY]), .cond_true(cond_true),
        .res(res), .flg_calc(flg_calc), .dst_we(dst_we), .flg_we(flg_we),
        .base_src1(base_src1)
    );

    pw_alu_merge #(.DATA_W(DATA_W)) u_merge (
        .dst_old(dst_old), .src1(src1), .res(res), .byte_en(byte_en),
        .base_src1(base_src1), .dst_we(dst_we), .flags_old(flags_old),
        .flg_calc(flg_calc), .flg_en(flag_en), .flg_we(flg_we),
        .dst_out(dst_nx), .flags_out(flg_nx)
    );

    // Output register: capture on an issued operation, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld   <= 1'b0;
            dst_new   <= '0;
            flags_new <= '0;
        end else begin
            res_vld <= op_vld;
            if (op_vld) begin
                dst_new   <= dst_nx;
                flags_new <= flg_nx;
            end
        end
    end

    // R1: a 1-byte non-move op keeps every upper destination byte.
    assert_upper_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(op_code) <= 4'd6 && $past(op_size) == '0)
        |-> dst_new[DATA_W-1:8] == $past(dst_old[DATA_W-1:8]));

    // R5: a zero enable mask leaves the whole flag word as it was.
    assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(flag_en) == '0) |-> flags_new == $past(flags_old));

    // R5: bits outside the writable set always pass through.
    assert_fixed_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (flags_new & ~FLAG_WR_MASK) == ($past(flags_old) & ~FLAG_WR_MASK));

    // R6: logic ops with carry enabled leave carry at zero.
    assert_logic_cf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(op_code) >= 4'd4 && $past(op_code) <= 4'd6
         && $past(flag_en[FB_CARRY])) |-> !flags_new[FB_CARRY]);

    // R7: a move with a false condition returns the old destination.
    assert_mov_false_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(op_code) == 4'd7 && !$past(cond_true))
        |-> dst_new == $past(dst_old));

    // R9: without an issued op, the destination output does not move.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_vld) |-> $stable(dst_new));

endmodule

// File: tb/test_pw_alu.sv
`timescale 1ns/1ps
module test_pw_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic        use_imm = 1'b0;
    logic [63:0] src1 = '0, src2 = '0, dst_old = '0;
    logic [7:0]  imm = '0;
    logic [11:0] flags_old = '0, flag_en = '0;
    logic        cond_true = 1'b0;
    logic        res_vld;
    logic [63:0] dst_new;
    logic [11:0] flags_new;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic [63:0] d;
        logic [11:0] f;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    pw_alu i_pw_alu (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
        .op_size(op_size), .use_imm(use_imm), .src1(src1), .src2(src2),
        .imm(imm), .dst_old(dst_old), .flags_old(flags_old),
        .flag_en(flag_en), .cond_true(cond_true), .res_vld(res_vld),
        .dst_new(dst_new), .flags_new(flags_new)
    );

    always #4 clk = ~clk;

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void model(input logic [3:0] op, input logic [1:0] sz,
            input logic ui, input logic [63:0] a, input logic [63:0] b2,
            input logic [7:0] im, input logic [63:0] d, input logic [11:0] f,
            input logic [11:0] fe, input logic c,
            output logic [63:0] ed, output logic [11:0] ef);
        int w;
        logic [63:0] m, b, r;
        logic [64:0] t;
        logic cf, of, af, ci, bi;
        logic [11:0] calc;
        w = 8 << sz;
        m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        b = ui ? {56'd0, im} : b2;
        ci = f[0];
        ed = d;
        ef = f;
        r = '0; cf = 0; of = 0; af = 0;
        if (op > 4'd7) return;
        if (op == 4'd7) begin
            if (c) ed = (a & ~m) | (b & m);
            return;
        end
        case (op)
            4'd0, 4'd1: begin
                bi = (op == 4'd1) && ci;
                t  = 65'(a & m) + 65'(b & m) + 65'(bi);
                r  = t[63:0] & m;
                cf = t[w];
                af = (int'(a[3:0]) + int'(b[3:0]) + int'(bi)) > 15;
                of = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
            end
            4'd2, 4'd3: begin
                bi = (op == 4'd3) && ci;
                r  = (a - b - 64'(bi)) & m;
                cf = 65'(a & m) < (65'(b & m) + 65'(bi));
                af = int'(a[3:0]) < (int'(b[3:0]) + int'(bi));
                of = (a[w-1] != b[w-1]) && (r[w-1] != a[w-1]);
            end
            4'd4: r = a & b & m;
            4'd5: r = (a | b) & m;
            default: r = (a ^ b) & m;
        endcase
        calc = '0;
        calc[0] = cf; calc[2] = ~^r[7:0]; calc[4] = af;
        calc[6] = (r == 0); calc[7] = r[w-1]; calc[11] = of;
        foreach (calc[p])
            if ((p == 0 || p == 2 || p == 4 || p == 6 || p == 7 || p == 11) && fe[p])
                ef[p] = calc[p];
        ed = (d & ~m) | r;
    endfunction

    // Driver: issues one operation and pushes its expected result.
    task automatic issue(logic [3:0] op, logic [1:0] sz, logic ui,
            logic [63:0] a, logic [63:0] b, logic [7:0] im, logic [63:0] d,
            logic [11:0] f, logic [11:0] fe, logic c, string tag);
        exp_t e;
        @(negedge clk);
        op_code = op; op_size = sz; use_imm = ui; src1 = a; src2 = b;
        imm = im; dst_old = d; flags_old = f; flag_en = fe; cond_true = c;
        op_vld = 1'b1;
        model(op, sz, ui, a, b, im, d, f, fe, c, e.d, e.f);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares each valid result against the scoreboard head.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && res_vld) begin
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: unexpected res_vld actual 1 expected 0");
            end else begin
                e = sb_q.pop_front();
                check64({e.tag, " dst"}, dst_new, e.d);
                check64({e.tag, " flags"}, 64'(flags_new), 64'(e.f));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL R9 watchdog: cycles %0d expected below 50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check64("R9 reset res_vld", 64'(res_vld), 64'd0);
        check64("R9 reset dst", dst_new, 64'd0);
        check64("R9 reset flags", 64'(flags_new), 64'd0);

        // R1 R8: byte add wraps to zero, carry out at width, upper garbage kept
        issue(4'd0, 2'd0, 0, 64'hA5A5_A5A5_A5A5_A5FF, 64'h7777_7777_7777_7701, 8'h0,
              64'h1122_3344_5566_7788, 12'h000, 12'hFFF, 0, "R1 R8 add8 wrap");
        // R8: byte signed overflow 0x7F + 1 with wide operands set
        issue(4'd0, 2'd0, 0, 64'hFFFF_FFFF_FFFF_FF7F, 64'hFFFF_FFFF_FFFF_FF01, 8'h0,
              64'hDEAD_BEEF_0000_0000, 12'h000, 12'hFFF, 0, "R8 add8 overflow");
        // R2: full width add
        issue(4'd0, 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 8'h0,
              64'h0, 12'h000, 12'hFFF, 0, "R2 add64");
        // R2 R8: word subtract with borrow
        issue(4'd2, 2'd1, 0, 64'h1234_0000_0000_0003, 64'h9999_0000_0000_0005, 8'h0,
              64'hCAFE_CAFE_CAFE_CAFE, 12'h000, 12'hFFF, 0, "R2 R8 sub16 borrow");
        // R2: 4-byte subtract signed overflow 0x80000000 - 1
        issue(4'd2, 2'd2, 0, 64'h0000_0001_8000_0000, 64'h1, 8'h0,
              64'hFFFF_FFFF_FFFF_FFFF, 12'h000, 12'hFFF, 0, "R2 sub32 overflow");
        // R4: add with carry-in
        issue(4'd1, 2'd2, 0, 64'h0000_0000_7FFF_FFFF, 64'h0, 8'h0,
              64'h0, 12'h001, 12'hFFF, 0, "R4 adc32 cf");
        // R4: subtract with borrow-in to zero
        issue(4'd3, 2'd0, 0, 64'h10, 64'h0F, 8'h0,
              64'h0, 12'h001, 12'hFFF, 0, "R4 sbb8 cf");
        // R3: immediate form ignores src2
        issue(4'd0, 2'd3, 1, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 8'hF0,
              64'h0, 12'h000, 12'hFFF, 0, "R3 imm add");
        // R6: logic ops clear CF, OF and AF
        issue(4'd4, 2'd1, 0, 64'hFFFF_FFFF_FFFF_8001, 64'h0000_0000_0000_8000, 8'h0,
              64'h5555_5555_5555_5555, 12'h811, 12'hFFF, 0, "R6 and16");
        issue(4'd5, 2'd0, 1, 64'h0, 64'h0, 8'h00, 64'hAAAA, 12'h811, 12'hFFF, 0, "R6 or8 zero");
        issue(4'd6, 2'd3, 0, 64'hF0F0, 64'hFFFF_FFFF_FFFF_0F0F, 8'h0,
              64'h0, 12'h811, 12'hFFF, 0, "R6 xor64");
        // R5: zero mask and partial mask; reserved bits pass
        issue(4'd0, 2'd0, 0, 64'hFF, 64'h1, 8'h0, 64'h0, 12'h72A, 12'h000, 0, "R5 zero mask");
        issue(4'd0, 2'd0, 0, 64'hFF, 64'h1, 8'h0, 64'h0, 12'h72A, 12'h041, 0, "R5 partial mask");
        issue(4'd2, 2'd3, 0, 64'h5, 64'h5, 8'h0, 64'h0, 12'h72A, 12'hFFF, 0, "R5 fixed bits");
        // R7: conditional move true and false
        issue(4'd7, 2'd0, 1, 64'h1111_2222_3333_4444, 64'h0, 8'h9C,
              64'hFFFF_FFFF_FFFF_FFFF, 12'h0C5, 12'hFFF, 1, "R7 cmov true");
        issue(4'd7, 2'd2, 0, 64'h1111_2222_3333_4444, 64'hABCD_EF01_2345_6789, 8'h0,
              64'h0F0F_0F0F_0F0F_0F0F, 12'h0C5, 12'hFFF, 0, "R7 cmov false");
        // R10: unused codes
        issue(4'd9, 2'd0, 0, 64'h1, 64'h1, 8'h0, 64'h1234, 12'h0AA, 12'hFFF, 0, "R10 code9");
        issue(4'd15, 2'd3, 1, 64'h7, 64'h7, 8'h7, 64'h4321, 12'h155, 12'hFFF, 1, "R10 code15");

        // Pseudo-random sweep over all widths and codes.
        for (int k = 0; k < 400; k++) begin
            issue(4'($urandom_range(0, 8)), 2'($urandom_range(0, 3)), 1'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom),
                  {$urandom, $urandom}, 12'($urandom), 12'($urandom), 1'($urandom),
                  "R1 R2 R8 random");
        end

        @(negedge clk);
        op_vld = 1'b0;
        @(negedge clk);
        // R9 idle hold: inputs change without op_vld
        held = dst_new;
        dst_old = ~dst_old; src1 = ~src1;
        repeat (3) @(negedge clk);
        check64("R9 idle res_vld", 64'(res_vld), 64'd0);
        check64("R9 idle hold dst", dst_new, held);
        check64("R9 scoreboard drained", 64'(sb_q.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule